// File: doc/BRIEF.md
# Registration-Aware Victim Way Selector

This block picks the way to evict from one set of a set-associative cache whose lines may be held in a Registered state. A Registered line is the only up-to-date copy of a synchronization variable, so evicting it is expensive. The selector therefore steers eviction away from such lines whenever it can. It keeps a small age counter for every way of every set. A fill or hit reported on the touch strobe makes the touched way the youngest and ages the rest. For the set being queried, the block combines those ages with the per-way valid and registered flags and reports a victim way at once.

When the owner commits an eviction, the block emits a one-cycle action record on the next clock. The record tells the cache whether the victim was Registered, which calls for a flush of dirty data at the owning first-level cache. At the second level it also calls for a recall of the inclusive first-level copy. A mode input turns off the state ranking, so the cache can be compared against a plain least-recently-used policy. Tag compare and data movement happen outside this block.

Top module: `rrs_victim_sel`

## Requirements
- R1: After reset every age counter is zero, so with all ways valid and none Registered the victim is way 0, and no action record is raised.
- R2: If any way in the queried set has its valid bit at 0, the victim is the lowest-numbered such way, and victim_reg is 0.
- R3: With the ranking mode active (plain_lru = 0), all ways valid and at least one way with its registered bit at 0, the victim is never a Registered way.
- R4: Within the candidate class, the way with the largest age is the victim. Among ways of equal age, the lowest index wins.
- R5: A touch of (set, way) clears that way's age to 0 and adds one to every other way of the same set, saturating at WAYS-1. Other sets are unchanged.
- R6: With plain_lru = 1 and all ways valid, the registered bits are ignored and the oldest valid way is the victim.
- R7: If all ways are valid and Registered, the oldest Registered way is the victim and victim_reg is 1.
- R8: One cycle after evict_go, act_valid is 1, act_way equals the victim of the commit cycle, and act_flush equals that cycle's victim_reg.
- R9: act_recall is 1 only when act_flush is 1 and the block is built for the second cache level (LEVEL = LVL_L2, the default). At the first level it stays 0.
- R10: When a touch and evict_go fall in the same cycle, the action record uses the victim computed from the ages before the touch, and the touch still takes effect.
- R11: act_valid is 0 in every cycle that does not follow an evict_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| plain_lru | input | 1 | 1: rank by age only, ignoring registered bits |
| touch_en | input | 1 | Access strobe that updates the ages |
| touch_set | input | SET_W | Set of the access |
| touch_way | input | WAY_W | Way of the access |
| q_set | input | SET_W | Set whose victim is requested |
| line_valid | input | WAYS | Per-way valid flags of the queried set |
| line_reg | input | WAYS | Per-way Registered flags of the queried set |
| evict_go | input | 1 | Commits eviction of the current victim |
| victim_way | output | WAY_W | Selected victim way |
| victim_reg | output | 1 | Selected victim is a valid Registered line |
| act_valid | output | 1 | Action record present |
| act_way | output | WAY_W | Way of the committed eviction |
| act_flush | output | 1 | Flush of the owning L1's dirty data required |
| act_recall | output | 1 | Recall of the inclusive L1 copy required |

## Verification
An access update and an eviction commit can fall in the same cycle on the same set, and the touched way can be the current victim. The bench provokes this by making way 15 the oldest, then raising touch_en on way 15 together with evict_go. It judges the result in two ways. The action record must still name way 15, which was the victim before the touch. Right after that edge, the live victim must have moved to way 14, showing that the touch was applied as well.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   typedef enum logic {
      LVL_L1 = 1'b0,
      LVL_L2 = 1'b1
   } cache_level_e;
endpackage

// File: rtl/rrs_age_bank.sv
module rrs_age_bank #(
   parameter int WAYS  = 16,
   parameter int SETS  = 4,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        touch_en,
   input  logic [SET_W-1:0]            touch_set,
   input  logic [WAY_W-1:0]            touch_way,
   input  logic [SET_W-1:0]            q_set,
   output logic [WAYS-1:0][AGE_W-1:0]  q_ages
);
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

   logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) age_q[s] <= '0;
      end else if (touch_en) begin
         for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == touch_way)
               age_q[touch_set][w] <= '0;
            else if (age_q[touch_set][w] != AGE_MAX)
               age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
         end
      end
   end

   assign q_ages = age_q[q_set];

   // R5: touched way is youngest on the following cycle
   a_r5_touch_youngest: assert property (@(posedge clk) disable iff (!rst_n)
      touch_en |=> age_q[$past(touch_set)][$past(touch_way)] == '0);
endmodule

// File: rtl/rrs_oldest.sv
module rrs_oldest #(
   parameter int WAYS  = 16,
   localparam int WAY_W = $clog2(WAYS),
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [WAYS-1:0]             cand,
   input  logic [WAYS-1:0][AGE_W-1:0]  ages,
   output logic                        found,
   output logic [WAY_W-1:0]            idx
);
   logic [AGE_W-1:0] best;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      best  = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (cand[w] && (!found || ages[w] > best)) begin
            found = 1'b1;
            idx   = WAY_W'(w);
            best  = ages[w];
         end
      end
   end

   // R4: a reported pick is always one of the candidates
   a_r4_pick_in_class: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> cand[idx]);
endmodule

// File: rtl/rrs_victim_sel.sv
module rrs_victim_sel #(
   parameter int                   WAYS  = 16,
   parameter int                   SETS  = 4,
   parameter rrs_pkg::cache_level_e LEVEL = rrs_pkg::LVL_L2,
   localparam int WAY_W = $clog2(WAYS),
   localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int AGE_W = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              plain_lru,
   input  logic              touch_en,
   input  logic [SET_W-1:0]  touch_set,
   input  logic [WAY_W-1:0]  touch_way,
   input  logic [SET_W-1:0]  q_set,
   input  logic [WAYS-1:0]   line_valid,
   input  logic [WAYS-1:0]   line_reg,
   input  logic              evict_go,
   output logic [WAY_W-1:0]  victim_way,
   output logic              victim_reg,
   output logic              act_valid,
   output logic [WAY_W-1:0]  act_way,
   output logic              act_flush,
   output logic              act_recall
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("WAYS must be a power of two of at least 2");
   end
   if (SETS < 1) begin : g_bad_sets
      $error("SETS must be at least 1");
   end

   logic [WAYS-1:0][AGE_W-1:0] ages;
   logic [WAYS-1:0]            free_mask;
   logic                       all_found, free_found, inv_found;
   logic [WAY_W-1:0]           all_idx, free_idx, inv_idx;

   rrs_age_bank #(.WAYS(WAYS), .SETS(SETS)) u_ages (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
      .touch_way(touch_way), .q_set(q_set), .q_ages(ages));

   assign free_mask = line_valid & ~line_reg;

   rrs_oldest #(.WAYS(WAYS)) u_old_all (
      .clk(clk), .rst_n(rst_n), .cand(line_valid), .ages(ages),
      .found(all_found), .idx(all_idx));

   rrs_oldest #(.WAYS(WAYS)) u_old_free (
      .clk(clk), .rst_n(rst_n), .cand(free_mask), .ages(ages),
      .found(free_found), .idx(free_idx));

   always_comb begin
      inv_found = 1'b0;
      inv_idx   = '0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!line_valid[w]) begin
            inv_found = 1'b1;
            inv_idx   = WAY_W'(w);
         end
      end
   end

   always_comb begin
      if (inv_found)                  victim_way = inv_idx;
      else if (!plain_lru && free_found) victim_way = free_idx;
      else                            victim_way = all_idx;
      victim_reg = !inv_found && line_reg[victim_way];
   end

   logic act_reg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act_way   <= '0;
         act_reg_q <= 1'b0;
      end else begin
         act_valid <= evict_go;
         act_way   <= evict_go ? victim_way : act_way;
         act_reg_q <= evict_go && victim_reg;
      end
   end

   assign act_flush = act_reg_q;

   if (LEVEL == rrs_pkg::LVL_L2) begin : g_l2_recall
      assign act_recall = act_reg_q;
      // R9: a recall never comes without the flush
      a_r9_recall_needs_flush: assert property (@(posedge clk) disable iff (!rst_n)
         act_recall |-> act_flush && act_valid);
   end else begin : g_l1_no_recall
      assign act_recall = 1'b0;
   end

   a_r2_invalid_first: assert property (@(posedge clk) disable iff (!rst_n)
      (|(~line_valid)) |-> !line_valid[victim_way] && !victim_reg);

   a_r3_free_preferred: assert property (@(posedge clk) disable iff (!rst_n)
      (!plain_lru && (&line_valid) && (|(~line_reg))) |-> !line_reg[victim_way]);

   a_r7_all_reg_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      ((&line_valid) && (&line_reg)) |-> victim_reg);

   a_r8_action_follows: assert property (@(posedge clk) disable iff (!rst_n)
      evict_go |=> act_valid && act_way == $past(victim_way)
                   && act_flush == $past(victim_reg));

   a_r11_no_spurious_action: assert property (@(posedge clk) disable iff (!rst_n)
      !evict_go |=> !act_valid);
endmodule

// File: tb/sim_rrs_victim_sel.sv
module sim_rrs_victim_sel;
   localparam int WAYS = 16;
   localparam int SETS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        plain_lru = 1'b0;
   logic        touch_en = 1'b0;
   logic [1:0]  touch_set = '0;
   logic [3:0]  touch_way = '0;
   logic [1:0]  q_set = '0;
   logic [15:0] line_valid = 16'hFFFF;
   logic [15:0] line_reg = 16'h0000;
   logic        evict_go = 1'b0;
   logic [3:0]  victim_way, act_way;
   logic        victim_reg, act_valid, act_flush, act_recall;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   rrs_victim_sel #(.WAYS(WAYS), .SETS(SETS)) u0 (
      .clk(clk), .rst_n(rst_n), .plain_lru(plain_lru), .touch_en(touch_en),
      .touch_set(touch_set), .touch_way(touch_way), .q_set(q_set),
      .line_valid(line_valid), .line_reg(line_reg), .evict_go(evict_go),
      .victim_way(victim_way), .victim_reg(victim_reg), .act_valid(act_valid),
      .act_way(act_way), .act_flush(act_flush), .act_recall(act_recall));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic touch(input int s, input int w);
      @(negedge clk);
      touch_en  = 1'b1;
      touch_set = 2'(s);
      touch_way = 4'(w);
      @(negedge clk);
      touch_en  = 1'b0;
   endtask

   task automatic query(input int s, input logic pl, input logic [15:0] v,
                        input logic [15:0] r);
      @(negedge clk);
      q_set = 2'(s); plain_lru = pl; line_valid = v; line_reg = r;
      #1;
   endtask

   // {plain, valid[15:0], reg[15:0], exp_way[3:0], exp_reg}; set 0 ages equal way index
   localparam logic [37:0] VEC [10] = '{
      {1'b0, 16'hFFFF, 16'h0000, 4'd15, 1'b0},  // R4 oldest overall
      {1'b0, 16'hFFFF, 16'h8000, 4'd14, 1'b0},  // R3
      {1'b0, 16'hFFFF, 16'hF000, 4'd11, 1'b0},  // R3
      {1'b0, 16'hFFFF, 16'hFFFF, 4'd15, 1'b1},  // R7
      {1'b1, 16'hFFFF, 16'h8000, 4'd15, 1'b1},  // R6
      {1'b0, 16'hFFFE, 16'h0000, 4'd0,  1'b0},  // R2
      {1'b0, 16'h7F7F, 16'h00FF, 4'd7,  1'b0},  // R2 lowest invalid
      {1'b0, 16'hFFFF, 16'h7FFF, 4'd15, 1'b0},  // R3 single free way
      {1'b0, 16'hFFFF, 16'hFFFE, 4'd0,  1'b0},  // R3 young free way beats old reg
      {1'b1, 16'hFFFF, 16'hFFFF, 4'd15, 1'b1}   // R6
   };

   initial begin
      #(200000 * 4);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1 reset state
      query(0, 1'b0, 16'hFFFF, 16'h0000);
      chk("R1 victim after reset", victim_way, 0);
      chk("R1 no action after reset", act_valid, 0);

      // R5 set up set 0 so that age equals way index
      for (int w = 15; w >= 0; w--) touch(0, w);

      for (int i = 0; i < 10; i++) begin
         query(0, VEC[i][37], VEC[i][36:21], VEC[i][20:5]);
         chk($sformatf("R3/R4/R6/R7 vec%0d way", i), victim_way, int'(VEC[i][4:1]));
         chk($sformatf("R2/R7 vec%0d reg", i), victim_reg, int'(VEC[i][0]));
      end

      // R5 other sets untouched, then saturation in set 1
      query(1, 1'b0, 16'hFFFF, 16'h0000);
      chk("R5 set 1 independent", victim_way, 0);
      for (int k = 0; k < 20; k++) touch(1, 0);
      query(1, 1'b0, 16'hFFFF, 16'h0000);
      chk("R5 saturated tie lowest", victim_way, 1);
      touch(1, 1);
      query(1, 1'b0, 16'hFFFF, 16'h0000);
      chk("R4 R5 after second touch", victim_way, 2);

      // R10 touch and commit in the same cycle on the current victim
      query(0, 1'b0, 16'hFFFF, 16'h0000);
      @(negedge clk);
      evict_go = 1'b1; touch_en = 1'b1; touch_set = 2'd0; touch_way = 4'd15;
      @(posedge clk); #1;
      chk("R10 action uses pre-touch victim", act_way, 15);
      chk("R8 act_valid", act_valid, 1);
      chk("R8 no flush for free victim", act_flush, 0);
      chk("R9 no recall for free victim", act_recall, 0);
      chk("R10 touch applied", victim_way, 14);
      @(negedge clk); evict_go = 1'b0; touch_en = 1'b0;
      @(posedge clk); #1;
      chk("R11 act_valid drops", act_valid, 0);

      // R8 R9 Registered victim
      query(0, 1'b0, 16'hFFFF, 16'hFFFF);
      chk("R7 all reg victim", victim_way, 14);
      @(negedge clk); evict_go = 1'b1;
      @(posedge clk); #1;
      chk("R8 act_way reg", act_way, 14);
      chk("R8 flush reg", act_flush, 1);
      chk("R9 recall reg", act_recall, 1);
      @(negedge clk); evict_go = 1'b0;
      @(posedge clk); #1;
      chk("R11 idle after reg evict", act_valid, 0);
      chk("R11 recall idle", act_recall, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule